// File: doc/BRIEF.md
# Vector Paired Subtract-With-Borrow Unit

This block runs a subtract-with-carry step over a wide vector in one clock cycle. The vector is cut into elements of 32 or 64 bits, and adjacent elements form pairs. In each pair the even element holds the working value and the odd element holds the borrow link. The even lane of the accumulator operand has the even lane of the subtrahend operand taken away from it. This is done as an addition of the bitwise inverse of the subtrahend plus a carry-in bit. The carry-in comes from bit 0 of the odd lane of a third operand, the carry source.

The wrapped difference goes to the even lane of the result. The carry-out of the element-width sum, zero-extended, fills the odd lane. A carry of 1 means no borrow occurred. Feeding one step's result back in as the next step's carry source chains borrows across words of any length.

An operation is accepted when the input strobe is high. Its result appears on the result bus, with the output strobe high, exactly one clock later. The latency never depends on the data. When no operation is accepted, the result bus keeps its last value.

Top module: `vec_pair_sbc`

## Requirements
- R1: The size select `in_wide` chooses 32-bit elements when 0 and 64-bit elements when 1.
- R2: Every pair in the vector is processed: VL / (2 × element width) pairs, up to and including the topmost pair.
- R3: For pair p, result lane 2p equals accumulator lane 2p plus the bitwise inverse of subtrahend lane 2p plus the carry-in, modulo 2^element width.
- R4: The carry-in of pair p is bit 0 of carry-source lane 2p+1. The other bits of that lane have no effect.
- R5: Result lane 2p+1 holds the carry-out of the element-width unsigned sum in bit 0 and zeros above it. For example, 5 − 3 with carry-in 1 gives 2 with carry 1, and 3 − 5 with carry-in 1 gives 2^W − 2 with carry 0.
- R6: The odd lanes of the subtrahend, the odd lanes of the accumulator and the even lanes of the carry source have no effect on the result.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high, and it carries that operation's result. The latency is one clock for every operand value.
- R8: A cycle with `in_valid` low gives `out_valid` low one clock later and leaves `out_result` unchanged.
- R9: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears `out_valid` and `out_result` to zero and takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept an operation this cycle |
| in_wide | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| in_acc | input | VL | Accumulator vector (minuend in even lanes) |
| in_sub | input | VL | Subtrahend vector (even lanes used) |
| in_csrc | input | VL | Carry-source vector (bit 0 of odd lanes used) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | VL | Differences in even lanes, zero-extended carries in odd lanes |

## Verification
Each accepted operation's result and strobe are due exactly one rising edge after the edge that samples `in_valid`. A reset or an idle cycle shows its effect on the same one-edge schedule. The bench drives operands on the falling edge and lets a single rising edge pass. It then compares both outputs on the next falling edge against a behavioural model, which it advances once per clock. Because of this, a result that arrives one cycle early or late shows up as a mismatch in the very cycle it should have appeared.

// File: rtl/vsbc_pkg.sv
package vsbc_pkg;

    // Narrow element width; the wide element is two narrow ones.
    localparam int unsigned NARROW_W = 32;
    localparam int unsigned WIDE_W   = 2 * NARROW_W;
    // A chunk holds one wide pair or two narrow pairs.
    localparam int unsigned CHUNK_W  = 2 * WIDE_W;

    typedef enum logic {
        ESZ_NARROW = 1'b0,
        ESZ_WIDE   = 1'b1
    } esize_e;

endpackage

// File: rtl/vsbc_add.sv
module vsbc_add #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    // a + NOT(b) + cin, carry out of the W-bit unsigned sum
    logic [W:0] total;

    always_comb begin
        total = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = total[W];
    end

endmodule

// File: rtl/vsbc_chunk.sv
module vsbc_chunk
    import vsbc_pkg::*;
#(
    parameter int unsigned LW = NARROW_W
) (
    input  logic [4*LW-1:0] acc,
    input  logic [4*LW-1:0] sub,
    input  logic [4*LW-1:0] csrc,
    input  esize_e          esz,
    output logic [4*LW-1:0] res
);

    localparam int unsigned HW = 2 * LW;

    logic          cin_lo;
    logic [LW-1:0] lo_sum, hi_sum, p1_sum;
    logic          lo_co, hi_co, p1_co;

    // Low slice is shared: narrow pair 0, or the lower half of the wide pair.
    assign cin_lo = (esz == ESZ_WIDE) ? csrc[HW] : csrc[LW];

    vsbc_add #(.W(LW)) u_lo (
        .a   (acc[LW-1:0]),
        .b   (sub[LW-1:0]),
        .cin (cin_lo),
        .sum (lo_sum),
        .cout(lo_co)
    );

    // Upper half of the wide pair, chained from the low slice.
    vsbc_add #(.W(LW)) u_hi (
        .a   (acc[HW-1:LW]),
        .b   (sub[HW-1:LW]),
        .cin (lo_co),
        .sum (hi_sum),
        .cout(hi_co)
    );

    // Second narrow pair (lanes 2 and 3 of the chunk).
    vsbc_add #(.W(LW)) u_p1 (
        .a   (acc[HW+LW-1:HW]),
        .b   (sub[HW+LW-1:HW]),
        .cin (csrc[HW+LW]),
        .sum (p1_sum),
        .cout(p1_co)
    );

    always_comb begin
        if (esz == ESZ_WIDE) begin
            res = {{(HW-1){1'b0}}, hi_co, hi_sum, lo_sum};
        end else begin
            res = {{(LW-1){1'b0}}, p1_co, p1_sum,
                   {(LW-1){1'b0}}, lo_co, lo_sum};
        end
    end

    // Bits that neither size ever reads.
    logic unused_chunk_bits;
    assign unused_chunk_bits = ^{acc[4*LW-1:HW+LW], sub[4*LW-1:HW+LW],
                                 csrc[LW-1:0], csrc[HW-1:LW+1],
                                 csrc[HW+LW-1:HW+1], csrc[4*LW-1:HW+LW+1]};

endmodule

// File: rtl/vec_pair_sbc.sv
module vec_pair_sbc
    import vsbc_pkg::*;
#(
    parameter int unsigned VL = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_wide,
    input  logic [VL-1:0] in_acc,
    input  logic [VL-1:0] in_sub,
    input  logic [VL-1:0] in_csrc,
    output logic          out_valid,
    output logic [VL-1:0] out_result
);

    localparam int unsigned N_CHUNK = VL / CHUNK_W;

    if ((VL == 0) || ((VL % CHUNK_W) != 0)) begin : g_vl_check
        $error("vec_pair_sbc: VL must be a nonzero multiple of 128");
    end

    typedef struct packed {
        logic          vld;
        logic [VL-1:0] res;
    } state_t;

    state_t        st_d, st_q;
    logic [VL-1:0] calc;
    esize_e        esz;

    assign esz = in_wide ? ESZ_WIDE : ESZ_NARROW;

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
        vsbc_chunk #(.LW(NARROW_W)) u_chunk (
            .acc (in_acc [g*CHUNK_W +: CHUNK_W]),
            .sub (in_sub [g*CHUNK_W +: CHUNK_W]),
            .csrc(in_csrc[g*CHUNK_W +: CHUNK_W]),
            .esz (esz),
            .res (calc   [g*CHUNK_W +: CHUNK_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;

endmodule

// File: rtl/vec_pair_sbc_chk.sv
module vec_pair_sbc_chk #(
    parameter int unsigned VL = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_wide,
    input logic [63:0]   acc_lo,
    input logic [63:0]   sub_lo,
    input logic          csrc_b32,
    input logic          csrc_b64,
    input logic          out_valid,
    input logic [VL-1:0] out_result
);

    logic [32:0] ref_n0;
    logic [64:0] ref_w0;
    logic        ext_bad_n, ext_bad_w;

    assign ref_n0 = {1'b0, acc_lo[31:0]} + {1'b0, ~sub_lo[31:0]} + {32'b0, csrc_b32};
    assign ref_w0 = {1'b0, acc_lo} + {1'b0, ~sub_lo} + {64'b0, csrc_b64};

    // Nonzero bits above the carry bit of any odd lane.
    always_comb begin
        ext_bad_n = 1'b0;
        ext_bad_w = 1'b0;
        for (int i = 0; i < VL / 64; i++) begin
            ext_bad_n = ext_bad_n | (|out_result[64*i+33 +: 31]);
        end
        for (int j = 0; j < VL / 128; j++) begin
            ext_bad_w = ext_bad_w | (|out_result[128*j+65 +: 63]);
        end
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_result == '0)));

    p_narrow_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_wide)) |-> !ext_bad_n);

    p_wide_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_wide)) |-> !ext_bad_w);

    p_narrow_pair0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_wide)) |-> (out_result[32:0] == $past(ref_n0)));

    p_wide_pair0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_wide)) |-> (out_result[64:0] == $past(ref_w0)));

endmodule

bind vec_pair_sbc vec_pair_sbc_chk #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .acc_lo    (in_acc[63:0]),
    .sub_lo    (in_sub[63:0]),
    .csrc_b32  (in_csrc[32]),
    .csrc_b64  (in_csrc[64]),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/vec_pair_sbc_bench.sv
module vec_pair_sbc_bench;

    localparam int VL = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_wide = 1'b0;
    logic [VL-1:0] in_acc = '0;
    logic [VL-1:0] in_sub = '0;
    logic [VL-1:0] in_csrc = '0;
    logic          out_valid;
    logic [VL-1:0] out_result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural model state
    bit            m_vld = 1'b0;
    logic [VL-1:0] m_res = '0;

    always #5 clk = ~clk;

    vec_pair_sbc #(.VL(VL)) u_vec_pair_sbc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_acc(in_acc), .in_sub(in_sub), .in_csrc(in_csrc),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [VL-1:0] ref_sbc(bit w, logic [VL-1:0] a,
                                              logic [VL-1:0] s, logic [VL-1:0] c);
        logic [VL-1:0] r;
        int es;
        r  = '0;
        es = w ? 64 : 32;
        for (int p = 0; p < VL / (2 * es); p++) begin
            int          base;
            logic [63:0] ea, eb;
            logic [64:0] t;
            bit          ci;
            base = 2 * p * es;
            ea = a[base +: 64];
            eb = s[base +: 64];
            ci = c[base + es];
            if (!w) begin
                t = {33'b0, ea[31:0]} + {33'b0, ~eb[31:0]} + {64'b0, ci};
                r[base +: 32]      = t[31:0];
                r[base + 32 +: 32] = {31'b0, t[32]};
            end else begin
                t = {1'b0, ea} + {1'b0, ~eb} + {64'b0, ci};
                r[base +: 64]      = t[63:0];
                r[base + 64 +: 64] = {63'b0, t[64]};
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VL-1:0] odd_mask(bit w);
        logic [VL-1:0] m;
        m = '0;
        if (!w) for (int i = 0; i < VL / 64; i++) m[64*i + 32 +: 32] = '1;
        else    for (int i = 0; i < VL / 128; i++) m[128*i + 64 +: 64] = '1;
        return m;
    endfunction

    task automatic chk_vec(string tag, logic [VL-1:0] got, logic [VL-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    // Called at a falling edge: drive, advance model, one rising edge, compare.
    task automatic step(bit rst, bit v, bit w, logic [VL-1:0] a,
                        logic [VL-1:0] s, logic [VL-1:0] c, string tag);
        rst_n    = !rst;
        in_valid = v;
        in_wide  = w;
        in_acc   = a;
        in_sub   = s;
        in_csrc  = c;
        if (rst) begin
            m_vld = 1'b0;
            m_res = '0;
        end else begin
            m_vld = v;
            if (v) m_res = ref_sbc(w, a, s, c);
        end
        @(posedge clk);
        @(negedge clk);
        chk_bit({tag, " valid"}, out_valid, m_vld);
        chk_vec({tag, " result"}, out_result, m_res);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] a, s, c, oa, os, oc, keep;
        @(negedge clk);
        // R9: reset wins over in_valid
        step(1, 1, 0, '1, '0, '1, "R9 reset");
        step(1, 1, 1, '1, '0, '1, "R9 reset");

        // R5: 5 - 3 with carry-in 1, narrow and wide
        a = '0; s = '0; c = '0;
        a[31:0] = 5; s[31:0] = 3; c[32] = 1'b1;
        step(0, 1, 0, a, s, c, "R5 narrow 5-3");
        chk_vec("R5 narrow lane0", {448'b0, out_result[63:0]}, {448'b0, 32'd1, 32'd2});
        a = '0; s = '0; c = '0;
        a[31:0] = 3; s[31:0] = 5; c[32] = 1'b1;
        step(0, 1, 0, a, s, c, "R5 narrow borrow");
        chk_vec("R5 borrow lane0", {448'b0, out_result[63:0]}, {448'b0, 32'd0, 32'hFFFF_FFFE});
        a = '0; s = '0; c = '0;
        a[63:0] = 5; s[63:0] = 3; c[64] = 1'b0;
        step(0, 1, 1, a, s, c, "R5 wide 5-3");
        chk_vec("R5 wide lane0", {384'b0, out_result[127:0]}, {384'b0, 64'd1, 64'd1});

        // R3: all-zero and all-ones operands, both sizes, both carry values
        for (int w = 0; w < 2; w++) begin
            step(0, 1, w[0], '0, '0, '0, "R3 zeros cin0");
            step(0, 1, w[0], '0, '0, '1, "R3 zeros cin1");
            step(0, 1, w[0], '1, '1, '1, "R3 ones");
            step(0, 1, w[0], '1, '0, '0, "R3 ones minus zero");
        end

        // R1/R7: random back-to-back stream with alternating sizes
        for (int i = 0; i < 40; i++) begin
            step(0, 1, i[0], rnd_vec(), rnd_vec(), rnd_vec(), "R1 R7 random");
        end

        // R4: carry-source odd lanes with upper bits set, bit 0 varied
        for (int w = 0; w < 2; w++) begin
            a = rnd_vec(); s = rnd_vec();
            c = rnd_vec() | odd_mask(w[0]);
            step(0, 1, w[0], a, s, c, "R4 csrc upper set");
            keep = out_result;
            oc = c & ~(odd_mask(w[0]) & ~(c << 1) & (c >> 0));
            oc = c ^ (odd_mask(w[0]) & rnd_vec());
            for (int i = 0; i < VL; i++) begin
                if (odd_mask(w[0])[i] && (i % (w[0] ? 64 : 32) == 0)) oc[i] = c[i];
            end
            step(0, 1, w[0], a, s, oc, "R4 upper bits changed");
            chk_vec("R4 same result", out_result, keep);
        end

        // R6: odd subtrahend/accumulator lanes and even carry lanes ignored
        for (int w = 0; w < 2; w++) begin
            a = rnd_vec(); s = rnd_vec(); c = rnd_vec();
            step(0, 1, w[0], a, s, c, "R6 base");
            keep = out_result;
            oa = a ^ (rnd_vec() & odd_mask(w[0]));
            os = s ^ (rnd_vec() & odd_mask(w[0]));
            oc = c ^ (rnd_vec() & ~odd_mask(w[0]));
            step(0, 1, w[0], oa, os, oc, "R6 altered");
            chk_vec("R6 same result", out_result, keep);
        end

        // R2: topmost pair explicitly, both sizes
        a = '0; s = '0; c = '0;
        a[VL-64 +: 32] = 32'd10; s[VL-64 +: 32] = 32'd4; c[VL-32] = 1'b0;
        step(0, 1, 0, a, s, c, "R2 top narrow");
        chk_vec("R2 top narrow pair", {448'b0, out_result[VL-1 -: 64]}, {448'b0, 32'd1, 32'd5});
        a = '0; s = '0; c = '0;
        a[VL-128 +: 64] = 64'd7; s[VL-128 +: 64] = 64'd9; c[VL-64] = 1'b1;
        step(0, 1, 1, a, s, c, "R2 top wide");
        chk_vec("R2 top wide pair", {384'b0, out_result[VL-1 -: 128]},
                {384'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE});

        // R8: idle cycles with changing inputs hold the result
        for (int i = 0; i < 5; i++) begin
            step(0, 0, i[0], rnd_vec(), rnd_vec(), rnd_vec(), "R8 idle hold");
        end
        step(0, 1, 1, rnd_vec(), rnd_vec(), rnd_vec(), "R7 after idle");
        step(0, 0, 0, rnd_vec(), rnd_vec(), rnd_vec(), "R8 idle after op");

        // R9: reset mid-run clears a held result
        step(1, 0, 0, '0, '0, '0, "R9 mid reset");
        step(0, 1, 0, rnd_vec(), rnd_vec(), rnd_vec(), "R7 after reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule